// File: doc/BRIEF.md
# Single-Wire Slave Bit-Slot Engine

This block is the time-slot layer of a slave on a single open-drain data line. It takes the raw line through a two-flop synchronizer and times every low period from the falling edge on. A short low period is a bit slot. For a write slot it samples the master's bit at a fixed delay. For a read slot it holds the line low itself when the bit to send is zero. A low period longer than the slot limit is a bus reset. The block puts each reset into one of three classes and, where the speed is known, answers with a presence pulse.

Two speed tables, standard and overdrive, set every timing constant. The `od_i` input picks the table, and the block latches it at each falling edge. A reset sets the speed for the presence pulse that follows: a long reset gives standard timing, a short reset in overdrive keeps overdrive timing. The upper layer owns the command protocol. It gets one `rx_valid_o` and one `tx_req_o` pulse for each completed slot, and one `rst_valid_o` pulse with a class code for each reset. It then updates `od_i`, `tx_en_i` and `tx_bit_i`. At standard speed only, a falling-edge filter drops low glitches shorter than `GLITCH_CLKS` clocks.

Top module: `ow_slot_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `drive_low_o`, `rx_valid_o`, `rst_valid_o` and `tx_req_o` are all 0.
- R2: Each completed slot gives exactly one single-cycle `rx_valid_o` pulse. `rx_bit_o` is the line level sampled 30 µs (standard) or 4 µs (overdrive) after the falling edge. A write-one (low for 1–15 µs standard, 1–2 µs overdrive) gives 1. A write-zero (low for at least 60 µs standard, at least 8 µs overdrive) gives 0.
- R3: If `tx_en_i`=1 and `tx_bit_i`=0 at the falling edge, `drive_low_o` holds the line low from slot start for 40 µs (standard) or 6 µs (overdrive). The master's sample point (16 µs standard, 3 µs overdrive after its edge) then reads 0. With `tx_bit_i`=1 or `tx_en_i`=0, the block never drives the line during the slot.
- R4: `tx_req_o` pulses for one cycle, together with `rx_valid_o`, once the line has returned high after the sample point. A low period that becomes a reset gives no `tx_req_o` and no `rx_valid_o`.
- R5: A low period longer than 120 µs (standard) or 16 µs (overdrive) is a reset. On release, `rst_valid_o` pulses once and `rst_class_o` gives the class. Code 1 means at least 480 µs (standard speed). Code 2 means the slot began in overdrive and the low lasted no more than 80 µs (overdrive kept). Code 3 means any other length (speed undefined). Code 0 never appears with the pulse.
- R6: After a class 1 or class 2 reset, the block drives a presence pulse. Standard timing waits 20 µs and then drives low for 100 µs. Overdrive timing waits 2 µs and then drives low for 10 µs. The pulse covers 60–72 µs (standard) or 7–10 µs (overdrive) after release. A class 3 reset gets no presence pulse.
- R7: At standard speed, a low pulse shorter than `GLITCH_CLKS` clocks is ignored: no `rx_valid_o`, no `tx_req_o`. At overdrive speed the same pulse is a valid slot and reads as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw line level (asynchronous) |
| od_i | input | 1 | 1 selects overdrive timing, latched at each falling edge |
| tx_en_i | input | 1 | The next slot is a read slot in which the block sends |
| tx_bit_i | input | 1 | Bit to send in the next read slot |
| drive_low_o | output | 1 | 1 pulls the line low (open-drain enable) |
| rx_valid_o | output | 1 | Single-cycle pulse: a slot finished and `rx_bit_o` is valid |
| rx_bit_o | output | 1 | Sampled bit of the last slot |
| rst_valid_o | output | 1 | Single-cycle pulse: a reset was classified |
| rst_class_o | output | 2 | Reset class: 1 standard, 2 overdrive kept, 3 undefined |
| tx_req_o | output | 1 | Single-cycle pulse: supply the next transmit bit |

## Verification
The bench places resets on both sides of each class boundary. A design that compared against the wrong table, or swapped the overdrive limit, would report class 2 for a 100 µs overdrive reset or class 3 for a 500 µs one. It checks the line level at the master's presence and read sample points. A presence pulse started late, or a read-zero released early, shows up there as a high line. It sends the same one-clock glitch at both speeds. A filter applied at both speeds would lose the overdrive bit, and a missing filter would count a phantom slot at standard speed.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;
  // timing tables in microseconds
  localparam int STD_SAMPLE_US  = 30;
  localparam int STD_HOLD_US    = 40;
  localparam int STD_SLOTMAX_US = 120;
  localparam int STD_PDH_US     = 20;
  localparam int STD_PRES_US    = 100;
  localparam int OD_SAMPLE_US   = 4;
  localparam int OD_HOLD_US     = 6;
  localparam int OD_SLOTMAX_US  = 16;
  localparam int OD_PDH_US      = 2;
  localparam int OD_PRES_US     = 10;
  localparam int RST_STD_MIN_US = 480;
  localparam int RST_OD_MAX_US  = 80;

  typedef enum logic [1:0] {
    RCLS_NONE  = 2'd0,
    RCLS_STD   = 2'd1,
    RCLS_OD    = 2'd2,
    RCLS_UNDEF = 2'd3
  } rst_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILT, ST_SLOT, ST_LONG, ST_WAIT, ST_PRES, ST_REL
  } slot_st_e;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ow_speed_table.sv
module ow_speed_table
  import ow_slot_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int CNT_W       = 12
) (
  input  logic             od_i,
  output logic [CNT_W-1:0] sample_o,
  output logic [CNT_W-1:0] hold_o,
  output logic [CNT_W-1:0] slotmax_o,
  output logic [CNT_W-1:0] pdh_o,
  output logic [CNT_W-1:0] pres_o
);
  localparam logic [CNT_W-1:0] S_SAMPLE  = CNT_W'(STD_SAMPLE_US  * CLKS_PER_US);
  localparam logic [CNT_W-1:0] S_HOLD    = CNT_W'(STD_HOLD_US    * CLKS_PER_US);
  localparam logic [CNT_W-1:0] S_SLOTMAX = CNT_W'(STD_SLOTMAX_US * CLKS_PER_US);
  localparam logic [CNT_W-1:0] S_PDH     = CNT_W'(STD_PDH_US     * CLKS_PER_US);
  localparam logic [CNT_W-1:0] S_PRES    = CNT_W'(STD_PRES_US    * CLKS_PER_US);
  localparam logic [CNT_W-1:0] O_SAMPLE  = CNT_W'(OD_SAMPLE_US   * CLKS_PER_US);
  localparam logic [CNT_W-1:0] O_HOLD    = CNT_W'(OD_HOLD_US     * CLKS_PER_US);
  localparam logic [CNT_W-1:0] O_SLOTMAX = CNT_W'(OD_SLOTMAX_US  * CLKS_PER_US);
  localparam logic [CNT_W-1:0] O_PDH     = CNT_W'(OD_PDH_US      * CLKS_PER_US);
  localparam logic [CNT_W-1:0] O_PRES    = CNT_W'(OD_PRES_US     * CLKS_PER_US);

  always_comb begin
    sample_o  = od_i ? O_SAMPLE  : S_SAMPLE;
    hold_o    = od_i ? O_HOLD    : S_HOLD;
    slotmax_o = od_i ? O_SLOTMAX : S_SLOTMAX;
    pdh_o     = od_i ? O_PDH     : S_PDH;
    pres_o    = od_i ? O_PRES    : S_PRES;
  end
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
  import ow_slot_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int CNT_W       = 12,
  parameter int GLITCH_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_s_i,
  input  logic             od_i,
  input  logic             tx_en_i,
  input  logic             tx_bit_i,
  input  logic [CNT_W-1:0] sample_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] slotmax_i,
  input  logic [CNT_W-1:0] pdh_i,
  input  logic [CNT_W-1:0] pres_i,
  output logic             spd_od_o,
  output logic             drive_low_o,
  output logic             rx_valid_o,
  output logic             rx_bit_o,
  output logic             rst_valid_o,
  output logic [1:0]       rst_class_o,
  output logic             tx_req_o
);
  localparam logic [CNT_W-1:0] RST_STD_MIN = CNT_W'(RST_STD_MIN_US * CLKS_PER_US);
  localparam logic [CNT_W-1:0] RST_OD_MAX  = CNT_W'(RST_OD_MAX_US  * CLKS_PER_US);
  localparam logic [CNT_W-1:0] CNT_SAT     = {CNT_W{1'b1}};

  // filter variant picked by parameter
  logic filt_en;
  logic [CNT_W-1:0] filt_last;
  generate
    if (GLITCH_CLKS > 1) begin : g_filt
      assign filt_en   = 1'b1;
      assign filt_last = CNT_W'(GLITCH_CLKS - 1);
    end else begin : g_nofilt
      assign filt_en   = 1'b0;
      assign filt_last = '0;
    end
  endgenerate

  slot_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             spd_od_q, rd_zero_q, cap_q;
  rst_cls_e         cls_d;

  always_comb begin
    if (cnt_q >= RST_STD_MIN)                  cls_d = RCLS_STD;
    else if (spd_od_q && cnt_q <= RST_OD_MAX)  cls_d = RCLS_OD;
    else                                       cls_d = RCLS_UNDEF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      spd_od_q    <= 1'b0;
      rd_zero_q   <= 1'b0;
      cap_q       <= 1'b1;
      drive_low_o <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_bit_o    <= 1'b0;
      rst_valid_o <= 1'b0;
      rst_class_o <= RCLS_NONE;
      tx_req_o    <= 1'b0;
    end else begin
      rx_valid_o  <= 1'b0;
      rst_valid_o <= 1'b0;
      tx_req_o    <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          drive_low_o <= 1'b0;
          if (!line_s_i) begin
            spd_od_q  <= od_i;
            rd_zero_q <= tx_en_i & ~tx_bit_i;
            cnt_q     <= CNT_W'(1);
            if (filt_en && !od_i) begin
              st_q <= ST_FILT;
            end else begin
              st_q        <= ST_SLOT;
              drive_low_o <= tx_en_i & ~tx_bit_i;
            end
          end
        end
        ST_FILT: begin
          if (line_s_i) begin
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= filt_last) begin
              st_q        <= ST_SLOT;
              drive_low_o <= rd_zero_q;
            end
          end
        end
        ST_SLOT: begin
          cnt_q       <= cnt_q + 1'b1;
          drive_low_o <= rd_zero_q && (cnt_q < hold_i);
          if (cnt_q == sample_i) cap_q <= line_s_i;
          if (!line_s_i && cnt_q >= slotmax_i) begin
            st_q        <= ST_LONG;
            drive_low_o <= 1'b0;
          end else if (line_s_i && !drive_low_o && cnt_q > sample_i) begin
            rx_valid_o <= 1'b1;
            rx_bit_o   <= cap_q;
            tx_req_o   <= 1'b1;
            cnt_q      <= '0;
            st_q       <= ST_IDLE;
          end
        end
        ST_LONG: begin
          if (line_s_i) begin
            rst_valid_o <= 1'b1;
            rst_class_o <= cls_d;
            spd_od_q    <= (cls_d == RCLS_OD);
            cnt_q       <= '0;
            st_q        <= (cls_d == RCLS_UNDEF) ? ST_IDLE : ST_WAIT;
          end else if (cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q >= pdh_i) begin
            cnt_q       <= '0;
            drive_low_o <= 1'b1;
            st_q        <= ST_PRES;
          end
        end
        ST_PRES: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q >= pres_i) begin
            drive_low_o <= 1'b0;
            st_q        <= ST_REL;
          end
        end
        ST_REL: begin
          if (line_s_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign spd_od_o = spd_od_q;
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_slot_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int GLITCH_CLKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_i,
  input  logic       od_i,
  input  logic       tx_en_i,
  input  logic       tx_bit_i,
  output logic       drive_low_o,
  output logic       rx_valid_o,
  output logic       rx_bit_o,
  output logic       rst_valid_o,
  output logic [1:0] rst_class_o,
  output logic       tx_req_o
);
  localparam int CNT_W = $clog2(RST_STD_MIN_US * CLKS_PER_US + 1) + 1;

  logic             line_s, spd_od;
  logic [CNT_W-1:0] sample, hold, slotmax, pdh, pres;

  ow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst(rst), .d_i(line_i), .q_o(line_s)
  );

  ow_speed_table #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(CNT_W)) tbl_i (
    .od_i(spd_od), .sample_o(sample), .hold_o(hold), .slotmax_o(slotmax),
    .pdh_o(pdh), .pres_o(pres)
  );

  ow_slot_fsm #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(CNT_W),
                .GLITCH_CLKS(GLITCH_CLKS)) fsm_i (
    .clk(clk), .rst(rst), .line_s_i(line_s), .od_i(od_i),
    .tx_en_i(tx_en_i), .tx_bit_i(tx_bit_i),
    .sample_i(sample), .hold_i(hold), .slotmax_i(slotmax),
    .pdh_i(pdh), .pres_i(pres), .spd_od_o(spd_od),
    .drive_low_o(drive_low_o), .rx_valid_o(rx_valid_o), .rx_bit_o(rx_bit_o),
    .rst_valid_o(rst_valid_o), .rst_class_o(rst_class_o), .tx_req_o(tx_req_o)
  );
endmodule

// File: rtl/ow_slot_engine_chk.sv
module ow_slot_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       drive_low_o,
  input logic       rx_valid_o,
  input logic       rst_valid_o,
  input logic [1:0] rst_class_o,
  input logic       tx_req_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!drive_low_o && !rx_valid_o && !rst_valid_o && !tx_req_o));

  p_rx_single_r2: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  p_treq_single_r4: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |=> !tx_req_o);

  p_no_slot_on_reset_r4: assert property (@(posedge clk) disable iff (rst)
    !(rst_valid_o && (tx_req_o || rx_valid_o)));

  p_rst_single_r5: assert property (@(posedge clk) disable iff (rst)
    rst_valid_o |=> !rst_valid_o);

  p_class_coded_r5: assert property (@(posedge clk) disable iff (rst)
    rst_valid_o |-> (rst_class_o != 2'd0));

  p_no_presence_undef_r6: assert property (@(posedge clk) disable iff (rst)
    (rst_valid_o && rst_class_o == 2'd3) |=> !drive_low_o);
endmodule

bind ow_slot_engine ow_slot_engine_chk chk_i (
  .clk(clk), .rst(rst), .drive_low_o(drive_low_o), .rx_valid_o(rx_valid_o),
  .rst_valid_o(rst_valid_o), .rst_class_o(rst_class_o), .tx_req_o(tx_req_o)
);

// File: tb/ow_slot_engine_tb_top.sv
module ow_slot_engine_tb_top;
  localparam int CPU = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_low = 1'b0;
  logic od = 1'b0, tx_en = 1'b0, tx_bit = 1'b0;
  logic line;
  logic drive_low, rx_valid, rx_bit, rst_valid, tx_req;
  logic [1:0] rst_class;

  always #2.5 clk = ~clk;
  assign line = !(m_low || drive_low);

  ow_slot_engine #(.CLKS_PER_US(CPU), .GLITCH_CLKS(3)) dut_i (
    .clk(clk), .rst(rst), .line_i(line), .od_i(od), .tx_en_i(tx_en),
    .tx_bit_i(tx_bit), .drive_low_o(drive_low), .rx_valid_o(rx_valid),
    .rx_bit_o(rx_bit), .rst_valid_o(rst_valid), .rst_class_o(rst_class),
    .tx_req_o(tx_req)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int rx_cnt, rst_cnt, treq_cnt, drv_cnt, last_cls, last_bit;

  always @(negedge clk) begin
    if (rx_valid)  begin rx_cnt++; last_bit = int'(rx_bit); end
    if (rst_valid) begin rst_cnt++; last_cls = int'(rst_class); end
    if (tx_req)    treq_cnt++;
    if (drive_low) drv_cnt++;
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_us(input int us);
    repeat (us * CPU) @(negedge clk);
  endtask

  task automatic clr;
    rx_cnt = 0; rst_cnt = 0; treq_cnt = 0; drv_cnt = 0; last_cls = 0; last_bit = -1;
  endtask

  // {od, low_us[9:0], tx_en, tx_bit, exp_rx, exp_bit, exp_rst, exp_cls[1:0], exp_drv}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 10'd5,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0}, // R2 std write-one
    {1'b0, 10'd70,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 std write-zero
    {1'b0, 10'd500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1}, // R5 R6 std reset
    {1'b0, 10'd200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0}, // R5 R6 undefined
    {1'b1, 10'd1,   1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0}, // R2 od write-one
    {1'b1, 10'd10,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 od write-zero
    {1'b1, 10'd60,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1}, // R5 R6 od kept
    {1'b1, 10'd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0}, // R5 od undefined
    {1'b1, 10'd500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1}, // R5 od long reset
    {1'b0, 10'd2,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1}, // R3 std read zero
    {1'b0, 10'd2,   1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0}, // R3 std read one
    {1'b1, 10'd1,   1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1}  // R3 od read zero
  };

  initial begin
    clr();
    repeat (5) @(negedge clk);
    chk("R1 drive_low in reset", int'(drive_low), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rx_valid after reset", int'(rx_valid), 0);
    chk("R1 rst_valid after reset", int'(rst_valid), 0);
    chk("R1 tx_req after reset", int'(tx_req), 0);
    wait_us(5);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      od = v[18]; tx_en = v[7]; tx_bit = v[6];
      wait_us(5);
      clr();
      m_low = 1'b1;
      wait_us(int'(v[17:8]));
      m_low = 1'b0;
      wait_us(250);
      chk($sformatf("R2 R4 vec%0d rx_valid count", i), rx_cnt, int'(v[5]));
      chk($sformatf("R4 vec%0d tx_req count", i), treq_cnt, int'(v[5]));
      if (v[5]) chk($sformatf("R2 R3 vec%0d rx_bit", i), last_bit, int'(v[4]));
      chk($sformatf("R5 vec%0d rst_valid count", i), rst_cnt, int'(v[3]));
      if (v[3]) chk($sformatf("R5 vec%0d class", i), last_cls, int'(v[2:1]));
      chk($sformatf("R3 R6 vec%0d drove line", i), int'(drv_cnt > 0), int'(v[0]));
    end
    tx_en = 1'b0;

    // R3: master sample point sees low during read-zero, standard
    od = 1'b0; tx_en = 1'b1; tx_bit = 1'b0; wait_us(5);
    m_low = 1'b1; wait_us(2); m_low = 1'b0; wait_us(14);
    chk("R3 std read-zero line at sample", int'(line), 0);
    wait_us(100);
    chk("R3 std line released after slot", int'(line), 1);
    // R3: overdrive
    od = 1'b1; wait_us(5);
    m_low = 1'b1; wait_us(1); m_low = 1'b0; wait_us(2);
    chk("R3 od read-zero line at sample", int'(line), 0);
    wait_us(30);
    tx_en = 1'b0;

    // R6: presence window, standard
    od = 1'b0; wait_us(5);
    m_low = 1'b1; wait_us(500); m_low = 1'b0;
    wait_us(5);
    chk("R6 std line high before presence", int'(line), 1);
    wait_us(55);
    chk("R6 std presence at 60us", int'(line), 0);
    wait_us(12);
    chk("R6 std presence at 72us", int'(line), 0);
    wait_us(100);
    // R6: presence window, overdrive
    od = 1'b1; wait_us(5);
    m_low = 1'b1; wait_us(60); m_low = 1'b0;
    wait_us(7);
    chk("R6 od presence at 7us", int'(line), 0);
    wait_us(3);
    chk("R6 od presence at 10us", int'(line), 0);
    wait_us(30);

    // R7: one-clock glitch at standard is ignored
    od = 1'b0; wait_us(5); clr();
    m_low = 1'b1; @(negedge clk); m_low = 1'b0;
    wait_us(60);
    chk("R7 std glitch rx_valid count", rx_cnt, 0);
    chk("R7 std glitch tx_req count", treq_cnt, 0);
    // R7: same pulse at overdrive is a slot reading 1
    od = 1'b1; wait_us(5); clr();
    m_low = 1'b1; @(negedge clk); m_low = 1'b0;
    wait_us(20);
    chk("R7 od short pulse rx_valid count", rx_cnt, 1);
    chk("R7 od short pulse rx_bit", last_bit, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule